// File: doc/BRIEF.md
# Rotating-Port Prefetch FIFO for a Paced Streamer

This block keeps a rate-paced output streamer supplied with 32-bit words from a shared memory. The memory has one port per processor, and that port rotates across eight interleaved banks. A start pulse loads a base address and empties the buffer. From then on the block reads consecutive words whenever its occupancy is below a low-water mark. Every read returns a fixed number of cycles after it is issued. Reads already in flight when the request stops still land, so the buffer tops up past the mark until it is completely full.

On the consuming side, a 32-bit phase accumulator produces one item each time it carries. Each item is a byte, a halfword or the whole word taken from the head word, least significant lane first. The head word is popped once its last lane has been used. The local processor can also run a sequential block write through the same memory port. Prefetch reads always win the port, and a write that loses its slot must wait for its bank to come round again. The block reports the write's lost cycles and the number of words fetched, so that the sharing of bandwidth can be measured.

Top module: `hub_prefetch_fifo`

## Requirements
- R1: While reset is applied and after it is released, with no start pulse given, the block issues no memory reads or writes. The fill level, the fetch count and the stall count are 0, and out_valid, underflow and cpu_busy are low.
- R2: After a start pulse, reads are issued to the start address and then to each following address in turn, one address per read. Every memory access, read or write, uses an address whose bank (address mod 8) is the bank facing the port in that cycle. As a result, (address − cycle) mod 8 is the same for every access.
- R3: The buffer holds NPROC+11 words (19 at the defaults). A read is issued only while fewer than NPROC+7 words are stored. Reads return 4 cycles after issue, so up to 5 words can still arrive after requesting stops. If nothing is consumed after a start, the level settles at exactly NPROC+11 and never goes above it. While consumption runs at a rate the port can sustain, underflow stays low.
- R4: A prefetch read and a processor write never share a cycle. When both want the port in the same cycle, the read takes it.
- R5: A block write of L words (cpu_len, with L > 0) that meets no prefetch traffic performs L writes to consecutive addresses in L consecutive cycles, with a stall count of 0. The wait for the first bank alignment is not counted as stall.
- R6: Each slot that a block write loses to a prefetch read delays the write by a full 8-cycle rotation. The stall count at the end is therefore a multiple of 8. If a block write starts in the same cycle as a 19-word prefetch burst and its address falls in the same bank, it ends with 24 stall cycles.
- R7: An item is produced in the cycle after each carry out of the accumulator. Adding nco_inc each cycle gives a carry every 2^32/nco_inc cycles. mode sets the item size: 0 gives bytes with 4 items per word, 1 gives halfwords with 2 items per word, and 2 gives whole words. Items are taken least significant lane first and are zero-extended on out_item.
- R8: If an item falls due while the buffer is empty, underflow is set and stays set. A start pulse clears underflow, the buffer, the reads in flight and the accumulator, so the level is 0 after that clock edge.
- R9: words_fetched counts the reads issued since the last start. Once traffic has settled, it equals the fill level plus the number of words popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Flush the buffer and begin prefetch at start_addr |
| start_addr | input | AW | First word address to prefetch |
| run | input | 1 | Enable the item accumulator |
| mode | input | 2 | Item size: 0 byte, 1 halfword, 2 word |
| nco_inc | input | 32 | Accumulator increment per cycle |
| mem_rd | output | 1 | Prefetch read issued this cycle |
| mem_wr | output | 1 | Block write issued this cycle |
| mem_addr | output | AW | Word address of this cycle's access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid 4 cycles after the read is issued |
| cpu_go | input | 1 | Begin a block write (accepted when idle) |
| cpu_addr | input | AW | First address of the block write |
| cpu_len | input | LW | Number of words to write |
| cpu_fill | input | 32 | Value written to every word |
| cpu_busy | output | 1 | Block write in progress |
| cpu_stalls | output | 32 | Cycles lost by the last block write |
| out_valid | output | 1 | out_item holds a new item |
| out_item | output | 32 | Current item, zero-extended |
| underflow | output | 1 | Sticky flag: an item was due while the buffer was empty |
| fill_level | output | LVW | Number of words stored |
| words_fetched | output | 32 | Reads issued since the last start |

## Verification
The bench goes after the fill limit. An off-by-one in the low-water compare, or a delay pipeline one stage too long, settles above 19 words or below it, and the level and fetch counts show this directly. The collision case starts a prefetch burst and a block write in the same bank in the same cycle. A design that let the write through, or that charged the lost slot as one cycle instead of a full rotation, reports something other than 24 stall cycles. Each item size is replayed against the memory contents with a check on item spacing, which catches a wrong lane order or a pop on the wrong lane. The underflow case checks that the flag stays set and that a start pulse clears both the flag and the data already in flight.

// File: rtl/hubpf_pkg.sv
package hubpf_pkg;
  typedef enum logic [1:0] {
    ITEM_BYTE = 2'd0,
    ITEM_HALF = 2'd1,
    ITEM_WORD = 2'd2
  } item_mode_e;
endpackage

// File: rtl/hubpf_store.sv
module hubpf_store #(
  parameter int DEPTH = 19,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           push,
  input  logic [DW-1:0]  push_data,
  input  logic           pop,
  output logic [LVW-1:0] level,
  output logic [DW-1:0]  head,
  output logic           empty
);
  logic [DW-1:0]  mem_q [DEPTH];
  logic [PW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LVW-1:0] cnt_q, cnt_d;
  logic           do_push, do_pop;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign do_push = push && !flush;
  assign do_pop  = pop && !flush && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = wrap_inc(wr_q);
      if (do_pop)  rd_d = wrap_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  assign level = cnt_q;
  assign head  = mem_q[rd_q];
endmodule

// File: rtl/hubpf_streamer.sv
module hubpf_streamer
  import hubpf_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          run,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] inc,
  input  logic [DW-1:0] head,
  input  logic          empty,
  output logic          pop,
  output logic          item_valid,
  output logic [DW-1:0] item,
  output logic          underflow
);
  localparam int BYTE_W = DW / 4;
  localparam int HALF_W = DW / 2;

  item_mode_e    m;
  logic [PW:0]   sum;
  logic          tick, last;
  logic [DW-1:0] sel;
  logic [PW-1:0] acc_q, acc_d;
  logic [1:0]    sub_q, sub_d;
  logic          val_q, val_d, uf_q, uf_d;
  logic [DW-1:0] item_q, item_d;

  assign m    = item_mode_e'(mode);
  assign sum  = {1'b0, acc_q} + {1'b0, inc};
  assign tick = run && sum[PW];

  always_comb begin
    sel  = '0;
    last = 1'b1;
    case (m)
      ITEM_BYTE: begin
        last              = (sub_q == 2'd3);
        sel[BYTE_W-1:0]   = head[BYTE_W*sub_q +: BYTE_W];
      end
      ITEM_HALF: begin
        last              = sub_q[0];
        sel[HALF_W-1:0]   = head[HALF_W*sub_q[0] +: HALF_W];
      end
      default: sel = head;
    endcase
  end

  assign pop = tick && !empty && last && !flush;

  always_comb begin
    acc_d  = acc_q;
    sub_d  = sub_q;
    val_d  = 1'b0;
    item_d = item_q;
    uf_d   = uf_q;
    if (flush) begin
      acc_d  = '0;
      sub_d  = '0;
      item_d = '0;
      uf_d   = 1'b0;
    end else begin
      if (run) acc_d = sum[PW-1:0];
      if (tick) begin
        if (empty) begin
          uf_d = 1'b1;
        end else begin
          val_d  = 1'b1;
          item_d = sel;
          sub_d  = last ? 2'd0 : sub_q + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sub_q  <= '0;
      val_q  <= 1'b0;
      item_q <= '0;
      uf_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      sub_q  <= sub_d;
      val_q  <= val_d;
      item_q <= item_d;
      uf_q   <= uf_d;
    end
  end

  assign item_valid = val_q;
  assign item       = item_q;
  assign underflow  = uf_q;
endmodule

// File: rtl/hubpf_blkwr.sv
module hubpf_blkwr #(
  parameter int AW = 20,
  parameter int LW = 16,
  parameter int BW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] first_addr,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] fill,
  input  logic [BW-1:0] face_bank,
  input  logic          taken,
  output logic          wr,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic [31:0]   stalls
);
  logic          busy_q, busy_d, armed_q, armed_d, aligned;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] left_q, left_d;
  logic [31:0]   stall_q, stall_d;
  logic [DW-1:0] data_q, data_d;

  assign aligned = busy_q && (addr_q[BW-1:0] == face_bank);
  assign wr      = aligned && !taken;

  always_comb begin
    busy_d  = busy_q;
    armed_d = armed_q;
    addr_d  = addr_q;
    left_d  = left_q;
    stall_d = stall_q;
    data_d  = data_q;
    if (!busy_q) begin
      if (go && (len != '0)) begin
        busy_d  = 1'b1;
        armed_d = 1'b0;
        addr_d  = first_addr;
        left_d  = len;
        stall_d = '0;
        data_d  = fill;
      end
    end else begin
      if (aligned) armed_d = 1'b1;
      if (wr) begin
        addr_d = addr_q + 1'b1;
        left_d = left_q - 1'b1;
        if (left_q == LW'(1)) busy_d = 1'b0;
      end else if (armed_q || aligned) begin
        stall_d = stall_q + 32'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      stall_q <= '0;
      data_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      armed_q <= armed_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      stall_q <= stall_d;
      data_q  <= data_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign busy    = busy_q;
  assign stalls  = stall_q;
endmodule

// File: rtl/hub_prefetch_fifo.sv
module hub_prefetch_fifo #(
  parameter int NPROC  = 8,
  parameter int LAG    = 5,
  parameter int AW     = 20,
  parameter int LW     = 16,
  parameter int BANKS  = 8,
  parameter int SLOT   = 3,
  localparam int DEPTH = NPROC + LAG + 6,
  localparam int LVW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic           run,
  input  logic [1:0]     mode,
  input  logic [31:0]    nco_inc,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           cpu_go,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [LW-1:0]  cpu_len,
  input  logic [31:0]    cpu_fill,
  output logic           cpu_busy,
  output logic [31:0]    cpu_stalls,
  output logic           out_valid,
  output logic [31:0]    out_item,
  output logic           underflow,
  output logic [LVW-1:0] fill_level,
  output logic [31:0]    words_fetched
);
  localparam int THRESH = NPROC + 7;
  localparam int PIPE   = LAG - 1;
  localparam int BW     = $clog2(BANKS);

  logic [1:0]      rst_sync_q;
  logic            rst_ni;
  logic [BW-1:0]   rot_q, face_bank;
  logic            act_q, act_d;
  logic [AW-1:0]   fetch_q, fetch_d;
  logic [PIPE-1:0] vpipe_q, vpipe_d;
  logic [31:0]     fetched_q, fetched_d;
  logic            fifo_rd, push, pop, empty;
  logic [31:0]     head;
  logic            cpu_wr;
  logic [AW-1:0]   cpu_wa;
  logic [31:0]     cpu_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rot_q <= '0;
    else         rot_q <= rot_q + 1'b1;
  end
  assign face_bank = rot_q + BW'(SLOT);

  assign fifo_rd = act_q && !start && (fill_level < LVW'(THRESH))
                   && (fetch_q[BW-1:0] == face_bank);
  assign push    = vpipe_q[PIPE-1];

  always_comb begin
    act_d     = act_q;
    fetch_d   = fetch_q;
    vpipe_d   = (vpipe_q << 1) | PIPE'(fifo_rd);
    fetched_d = fetched_q;
    if (start) begin
      act_d     = 1'b1;
      fetch_d   = start_addr;
      vpipe_d   = '0;
      fetched_d = '0;
    end else if (fifo_rd) begin
      fetch_d   = fetch_q + 1'b1;
      fetched_d = fetched_q + 32'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      fetch_q   <= '0;
      vpipe_q   <= '0;
      fetched_q <= '0;
    end else begin
      act_q     <= act_d;
      fetch_q   <= fetch_d;
      vpipe_q   <= vpipe_d;
      fetched_q <= fetched_d;
    end
  end

  hubpf_store #(.DEPTH(DEPTH), .DW(32)) u_store (
    .clk(clk), .rst_n(rst_ni), .flush(start), .push(push), .push_data(mem_rdata),
    .pop(pop), .level(fill_level), .head(head), .empty(empty)
  );

  hubpf_streamer #(.DW(32), .PW(32)) u_streamer (
    .clk(clk), .rst_n(rst_ni), .flush(start), .run(run), .mode(mode), .inc(nco_inc),
    .head(head), .empty(empty), .pop(pop), .item_valid(out_valid), .item(out_item),
    .underflow(underflow)
  );

  hubpf_blkwr #(.AW(AW), .LW(LW), .BW(BW), .DW(32)) u_blkwr (
    .clk(clk), .rst_n(rst_ni), .go(cpu_go), .first_addr(cpu_addr), .len(cpu_len),
    .fill(cpu_fill), .face_bank(face_bank), .taken(fifo_rd), .wr(cpu_wr),
    .wr_addr(cpu_wa), .wr_data(cpu_wd), .busy(cpu_busy), .stalls(cpu_stalls)
  );

  assign mem_rd        = fifo_rd;
  assign mem_wr        = cpu_wr;
  assign mem_addr      = fifo_rd ? fetch_q : cpu_wa;
  assign mem_wdata     = cpu_wd;
  assign words_fetched = fetched_q;
endmodule

// File: rtl/hubpf_checker.sv
module hubpf_checker #(
  parameter int DEPTH = 19,
  parameter int LVW   = 5,
  parameter int AW    = 20,
  parameter int BANKS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [AW-1:0]  mem_addr,
  input logic [LVW-1:0] fill_level,
  input logic           underflow,
  input logic           cpu_busy,
  input logic [31:0]    cpu_stalls
);
  a_r4_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r3_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVW'(DEPTH));

  a_r3_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown($past(fill_level)) |-> (fill_level <= $past(fill_level) + 1'b1));

  a_r2_read_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + 1'b1);

  a_r5_write_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && $past(mem_wr) |-> mem_addr == $past(mem_addr) + 1'b1);

  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !start |=> underflow);

  a_r6_stall_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_busy) |-> (cpu_stalls % BANKS) == 0);
endmodule

bind hub_prefetch_fifo hubpf_checker #(
  .DEPTH(DEPTH), .LVW(LVW), .AW(AW), .BANKS(BANKS)
) u_hubpf_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .fill_level(fill_level), .underflow(underflow),
  .cpu_busy(cpu_busy), .cpu_stalls(cpu_stalls)
);

// File: tb/test_hub_prefetch_fifo.sv
module test_hub_prefetch_fifo;
  localparam int NPROC  = 8;
  localparam int AW     = 20;
  localparam int LW     = 16;
  localparam int DEPTH  = NPROC + 11;
  localparam int THRESH = NPROC + 7;
  localparam int LVW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, start, run, cpu_go;
  logic [AW-1:0]  start_addr, cpu_addr;
  logic [1:0]     mode;
  logic [31:0]    nco_inc, cpu_fill;
  logic [LW-1:0]  cpu_len;
  logic           mem_rd, mem_wr, cpu_busy, out_valid, underflow;
  logic [AW-1:0]  mem_addr;
  logic [31:0]    mem_wdata, mem_rdata, cpu_stalls, out_item, words_fetched;
  logic [LVW-1:0] fill_level;

  hub_prefetch_fifo i_hub_prefetch_fifo (.*);

  function automatic logic [31:0] memf(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  logic [AW-1:0] rp0, rp1, rp2, rp3;
  always @(posedge clk) begin
    rp0 <= mem_addr; rp1 <= rp0; rp2 <= rp1; rp3 <= rp2;
  end
  assign mem_rdata = memf(rp3);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [AW-1:0] exp_rd, exp_wr, st_base;
  int seq_err = 0, wseq_err = 0, align_err = 0, rd_cnt = 0, wr_cnt = 0;
  int wr_first = -1, wr_last = -1, have_off = 0;
  logic [2:0] ref_off;
  int item_err = 0, gap_err = 0, item_cnt = 0, last_item = -1, gap = 4, ratio = 4;
  int wi = 0, si = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (mem_addr !== exp_rd) seq_err++;
        exp_rd = mem_addr + 1'b1;
        rd_cnt++;
      end
      if (mem_wr) begin
        if (mem_addr !== exp_wr) wseq_err++;
        exp_wr = exp_wr + 1'b1;
        wr_cnt++;
        if (wr_first < 0) wr_first = cyc;
        wr_last = cyc;
      end
      if (mem_rd || mem_wr) begin
        logic [2:0] off;
        off = mem_addr[2:0] - 3'(cyc);
        if (have_off == 0) begin ref_off = off; have_off = 1; end
        else if (off != ref_off) align_err++;
      end
      if (out_valid) begin
        logic [31:0] w, e;
        w = memf(st_base + AW'(wi));
        if (ratio == 4)      e = (w >> (8 * si)) & 32'hFF;
        else if (ratio == 2) e = (w >> (16 * si)) & 32'hFFFF;
        else                 e = w;
        if (out_item !== e) item_err++;
        if (last_item >= 0 && (cyc - last_item) != gap) gap_err++;
        last_item = cyc;
        item_cnt++;
        si++;
        if (si == ratio) begin si = 0; wi++; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    start = 1'b1; start_addr = a; exp_rd = a; st_base = a;
    step(1);
    start = 1'b0;
  endtask

  task automatic t_reset();
    sample();
    check(!mem_rd && !mem_wr, "R1 no access", {mem_rd, mem_wr}, 0);
    check(fill_level == 0, "R1 level", fill_level, 0);
    check(words_fetched == 0 && cpu_stalls == 0, "R1 counters", words_fetched + cpu_stalls, 0);
    check(!out_valid && !underflow && !cpu_busy, "R1 flags", {out_valid, underflow, cpu_busy}, 0);
  endtask

  task automatic t_fill();
    rd_cnt = 0; seq_err = 0;
    mode = 2'd2; run = 1'b0;
    pulse_start(20'h00100);
    step(60);
    sample();
    check(fill_level == DEPTH, "R3 settled level", fill_level, DEPTH);
    check(words_fetched == DEPTH, "R9 fetch count", words_fetched, DEPTH);
    check(rd_cnt == DEPTH, "R3 reads issued", rd_cnt, DEPTH);
    check(seq_err == 0, "R2 sequential reads", seq_err, 0);
  endtask

  task automatic t_cpu_alone();
    wr_cnt = 0; wseq_err = 0; wr_first = -1; wr_last = -1;
    cpu_go = 1'b1; cpu_addr = 20'h00045; cpu_len = 16'd20; cpu_fill = 32'hCAFE0001;
    exp_wr = 20'h00045;
    step(1);
    cpu_go = 1'b0;
    for (int k = 0; k < 200 && cpu_busy; k++) step(1);
    sample();
    check(cpu_stalls == 0, "R5 no stall", cpu_stalls, 0);
    check(wr_cnt == 20, "R5 write count", wr_cnt, 20);
    check(wr_last - wr_first + 1 == 20, "R5 back-to-back", wr_last - wr_first + 1, 20);
    check(wseq_err == 0, "R5 sequential writes", wseq_err, 0);
  endtask

  task automatic t_conflict();
    wr_cnt = 0; wseq_err = 0; wr_first = -1;
    start = 1'b1; start_addr = 20'h00200; exp_rd = 20'h00200; st_base = 20'h00200;
    cpu_go = 1'b1; cpu_addr = 20'h00300; cpu_len = 16'd16; exp_wr = 20'h00300;
    step(1);
    start = 1'b0; cpu_go = 1'b0;
    for (int k = 0; k < 400 && cpu_busy; k++) step(1);
    sample();
    check(cpu_stalls == 24, "R6 stall cycles", cpu_stalls, 24);
    check(cpu_stalls % 8 == 0, "R6 whole rotations", cpu_stalls % 8, 0);
    check(wr_cnt == 16, "R4 writes completed", wr_cnt, 16);
    check(wseq_err == 0, "R4 write order", wseq_err, 0);
  endtask

  task automatic t_stream(input logic [1:0] md, input logic [31:0] inc, input int g, input int r);
    run = 1'b0; mode = md; seq_err = 0;
    pulse_start(20'h00400 + AW'(r * 16));
    wi = 0; si = 0; gap = g; ratio = r;
    step(40);
    item_err = 0; gap_err = 0; item_cnt = 0; last_item = -1;
    run = 1'b1; nco_inc = inc;
    step(240);
    run = 1'b0;
    step(30);
    sample();
    check(item_err == 0, "R7 item values", item_err, 0);
    check(gap_err == 0, "R7 item spacing", gap_err, 0);
    check(item_cnt >= 240 / g - 2, "R7 item count", item_cnt, 240 / g - 2);
    check(!underflow, "R3 keeps up", underflow, 0);
    check(fill_level >= THRESH && fill_level <= DEPTH, "R3 refill level", fill_level, THRESH);
    check(words_fetched == fill_level + item_cnt / r, "R9 fetched balance",
          words_fetched, fill_level + item_cnt / r);
    check(seq_err == 0, "R2 stream reads", seq_err, 0);
  endtask

  task automatic t_underflow();
    mode = 2'd2; nco_inc = 32'hFFFF_FFFF; run = 1'b1;
    pulse_start(20'h00800);
    step(10);
    sample();
    check(underflow, "R8 underflow set", underflow, 1);
    run = 1'b0;
    step(6);
    sample();
    check(underflow, "R8 underflow sticky", underflow, 1);
    #1;
    pulse_start(20'h00900);
    #1;
    check(!underflow, "R8 start clears flag", underflow, 0);
    check(fill_level == 0, "R8 start empties", fill_level, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; run = 1'b0; cpu_go = 1'b0;
    start_addr = '0; cpu_addr = '0; mode = 2'd2; nco_inc = '0;
    cpu_fill = '0; cpu_len = '0; exp_rd = '0; exp_wr = '0; st_base = '0;
    step(4);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_fill();
    t_cpu_alone();
    t_conflict();
    t_stream(2'd0, 32'h4000_0000, 4, 4);
    t_stream(2'd1, 32'h2000_0000, 8, 2);
    t_stream(2'd2, 32'h8000_0000, 2, 1);
    t_underflow();
    check(align_err == 0, "R2 bank alignment", align_err, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule